// File: doc/BRIEF.md
# Asynchronous Memory-Bus Mailbox Slave

This block lets on-chip logic appear to a processor as a four-word, SRAM-like window on the processor's asynchronous external memory bus. The processor selects the window with an active-low chip select. It reads and writes with active-low strobes, a two-bit word offset and a data bus that is 8 or 16 bits wide (`DATA_W`). The bus has no clock. Every bus pin therefore passes through a two-stage synchroniser plus one edge-detect register in the local clock domain before any decode takes place. The processor must hold each strobe, together with the address and the data, for at least four local clock periods.

Two FIFOs carry the traffic. The inbox carries words from the processor to the logic. The outbox carries words from the logic to the processor. A ready pin shows whether the inbox has room. A request pin shows that the outbox holds data, gated by a software enable, so the processor can start an interrupt or a DMA transfer instead of polling. Overflow and underflow are sticky status flags that software clears by writing ones.

The data bus is split into an input, an output and an output-enable pin. The pad ring builds the tri-state buffer from these.

Top module: `mbus_mailbox_slave`

## Requirements
- R1: After reset, `bus_req` is 0, `bus_ready` is 1, `in_valid` is 0, `out_full` is 0 and `bus_dout` is 0.
- R2: A write commits once, on the synchronised rising edge of `bus_wr_n`, provided `bus_cs_n` was low in the preceding sample. Its effect shows on the logic side at the third clock edge after the first edge that samples `bus_wr_n` high.
- R3: A write at offset 1 appends the word to the inbox. The logic side sees the oldest word on `in_data` with `in_valid` high, and `in_pop` removes it. Words leave in the order they were written.
- R4: `bus_ready` is high exactly when the inbox holds fewer than `FIFO_DEPTH` words.
- R5: A write at offset 1 while the inbox is full is discarded and sets the overflow flag (status bit 2). The flag stays set until software clears it.
- R6: A read at offset 2 acts on the synchronised falling edge of `bus_rd_n` while chip select is low. It returns and removes exactly one outbox word. If the outbox is empty, it returns 0 and sets the underflow flag (status bit 3).
- R7: A read at offset 0 returns bit 0 = inbox has room, bit 1 = outbox not empty, bit 2 = overflow and bit 3 = underflow, with all other bits 0. A write at offset 0 clears bit 2 and bit 3 where the written data has a 1 in that position.
- R8: Offset 3 bit 0 is the request enable. It resets to 0 and reads back in bit 0. `bus_req` is high exactly when the enable is 1 and the outbox is not empty.
- R9: `bus_doe` is high only while `bus_cs_n` and `bus_rd_n` are both low. `bus_dout` holds the word captured when the read began.
- R10: `out_push` while `out_full` is high and `in_pop` while `in_valid` is low are ignored. A write at offset 2 changes no state, and a read at offset 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_rd_n | input | 1 | Read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_addr | input | 2 | Word offset within the window |
| bus_din | input | DATA_W | Write data from the bus pad |
| bus_dout | output | DATA_W | Read data toward the bus pad |
| bus_doe | output | 1 | Pad output enable |
| bus_req | output | 1 | Interrupt/DMA request: outbox data waiting |
| bus_ready | output | 1 | Inbox can accept a word |
| in_data | output | DATA_W | Oldest inbox word |
| in_valid | output | 1 | Inbox not empty |
| in_pop | input | 1 | Logic side removes the inbox head |
| out_data | input | DATA_W | Word from logic into the outbox |
| out_push | input | 1 | Logic side appends `out_data` |
| out_full | output | 1 | Outbox full |

## Verification
A wrong FIFO count or pointer shows at once on `bus_ready`, `out_full`, `in_valid` or `in_data`, at the first clock edge after the bad update. A wrong edge detect, such as a double commit or a missed pop, shows as an extra or missing word three edges after the strobe changes. A wrong sticky flag or enable stays hidden until the next status or control read, or shows on `bus_req` when the outbox next holds data. The reference model in the bench tracks every one of these outputs on every cycle, so a divergence is reported in the cycle it appears.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    OFS_STATUS = 2'd0,
    OFS_INBOX  = 2'd1,
    OFS_OUTBOX = 2'd2,
    OFS_CTRL   = 2'd3
  } mbox_ofs_e;

  localparam int ST_ROOM  = 0;
  localparam int ST_AVAIL = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_UNF   = 3;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  // R5: a push into a full FIFO without a pop leaves the level unchanged
  a_r5_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
  // R4: the level never exceeds the depth
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3: full and empty are exclusive
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/mbus_mailbox_slave.sv
module mbus_mailbox_slave
  import mbox_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_req,
  output logic              bus_ready,
  output logic [DATA_W-1:0] in_data,
  output logic              in_valid,
  input  logic              in_pop,
  input  logic [DATA_W-1:0] out_data,
  input  logic              out_push,
  output logic              out_full
);
  localparam int RAW_W = 3 + 2 + DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ln;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ln = rst_pipe[1];

  // bus pins into the local clock, active-high controls
  logic [RAW_W-1:0] raw, smp, smp_q;
  assign raw = {~bus_cs_n, ~bus_rd_n, ~bus_wr_n, bus_addr, bus_din};

  mbox_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ln), .d(raw), .q(smp)
  );

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) smp_q <= '0;
    else         smp_q <= smp;
  end

  logic              s_cs, s_rd, q_cs, q_rd, q_wr, s_wr;
  logic [1:0]        s_addr, q_addr;
  logic [DATA_W-1:0] q_data;
  assign {s_cs, s_rd, s_wr} = smp[RAW_W-1 -: 3];
  assign s_addr             = smp[DATA_W +: 2];
  assign {q_cs, q_rd, q_wr} = smp_q[RAW_W-1 -: 3];
  assign q_addr             = smp_q[DATA_W +: 2];
  assign q_data             = smp_q[DATA_W-1:0];

  logic wr_evt, rd_evt;
  assign wr_evt = q_wr && !s_wr && q_cs;
  assign rd_evt = s_rd && !q_rd && s_cs;

  // mailboxes
  logic              in_full, in_empty, out_empty, inbox_push, outbox_pop, clr_wr;
  logic [DATA_W-1:0] out_head;

  assign inbox_push = wr_evt && (q_addr == OFS_INBOX);
  assign outbox_pop = rd_evt && (s_addr == OFS_OUTBOX);
  assign clr_wr     = wr_evt && (q_addr == OFS_STATUS);

  mbox_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_inbox (
    .clk(clk), .rst_n(rst_ln), .push(inbox_push), .wdata(q_data),
    .pop(in_pop), .rdata(in_data), .full(in_full), .empty(in_empty)
  );

  mbox_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_outbox (
    .clk(clk), .rst_n(rst_ln), .push(out_push), .wdata(out_data),
    .pop(outbox_pop), .rdata(out_head), .full(out_full), .empty(out_empty)
  );

  // status, control, read latch
  logic              ovf_q, ovf_d, unf_q, unf_d, req_en_q, req_en_d;
  logic [DATA_W-1:0] rd_lat_q, rd_lat_d, rd_word;

  always_comb begin
    rd_word = '0;
    unique case (mbox_ofs_e'(s_addr))
      OFS_STATUS: begin
        rd_word[ST_ROOM]  = !in_full;
        rd_word[ST_AVAIL] = !out_empty;
        rd_word[ST_OVF]   = ovf_q;
        rd_word[ST_UNF]   = unf_q;
      end
      OFS_OUTBOX: rd_word = out_empty ? '0 : out_head;
      OFS_CTRL:   rd_word[0] = req_en_q;
      default:    rd_word = '0;
    endcase
  end

  always_comb begin
    ovf_d    = ovf_q;
    unf_d    = unf_q;
    req_en_d = req_en_q;
    rd_lat_d = rd_lat_q;
    if (clr_wr) begin
      if (q_data[ST_OVF]) ovf_d = 1'b0;
      if (q_data[ST_UNF]) unf_d = 1'b0;
    end
    if (inbox_push && in_full)  ovf_d = 1'b1;
    if (outbox_pop && out_empty) unf_d = 1'b1;
    if (wr_evt && (q_addr == OFS_CTRL)) req_en_d = q_data[0];
    if (rd_evt) rd_lat_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
      req_en_q <= 1'b0;
      rd_lat_q <= '0;
    end else begin
      ovf_q    <= ovf_d;
      unf_q    <= unf_d;
      req_en_q <= req_en_d;
      rd_lat_q <= rd_lat_d;
    end
  end

  assign bus_dout  = rd_lat_q;
  assign bus_doe   = !bus_cs_n && !bus_rd_n;
  assign bus_req   = req_en_q && !out_empty;
  assign bus_ready = !in_full;
  assign in_valid  = !in_empty;

  // R2: one write strobe commits at most one inbox word
  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_ln)
    inbox_push |=> !inbox_push);
  // R6: one read strobe pops at most one outbox word
  a_r6_single_pop: assert property (@(posedge clk) disable iff (!rst_ln)
    outbox_pop |=> !outbox_pop);
  // R6: reading an empty outbox raises underflow
  a_r6_underflow_set: assert property (@(posedge clk) disable iff (!rst_ln)
    (outbox_pop && out_empty) |=> unf_q);
  // R5: overflow stays set unless a status write arrives
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_ln)
    (ovf_q && !clr_wr) |=> ovf_q);
endmodule

// File: tb/mbus_mailbox_slave_test.sv
module mbus_mailbox_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int WDOG  = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_cs_n, bus_rd_n, bus_wr_n;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_din, bus_dout, in_data, out_data;
  logic          bus_doe, bus_req, bus_ready, in_valid, in_pop, out_push, out_full;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_mailbox_slave #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_req(bus_req),
    .bus_ready(bus_ready), .in_data(in_data), .in_valid(in_valid),
    .in_pop(in_pop), .out_data(out_data), .out_push(out_push),
    .out_full(out_full)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [DW-1:0] inq[$];
  logic [DW-1:0] outq[$];
  bit            m_ovf, m_unf, m_en;
  logic [DW-1:0] m_lat;
  bit            s1_cs, s1_rd, s1_wr, s2_cs, s2_rd, s2_wr, q_cs, q_rd, q_wr;
  logic [1:0]    s1_a, s2_a, q_a;
  logic [DW-1:0] s1_d, s2_d, q_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      inq.delete(); outq.delete();
      m_ovf = 0; m_unf = 0; m_en = 0; m_lat = '0;
      s1_cs = 0; s1_rd = 0; s1_wr = 0; s2_cs = 0; s2_rd = 0; s2_wr = 0;
      q_cs = 0; q_rd = 0; q_wr = 0;
      s1_a = 0; s2_a = 0; q_a = 0; s1_d = 0; s2_d = 0; q_d = 0;
    end else begin
      bit wr_e, rd_e, ifull, iempty, ofull, oempty, do_opop, do_ipush;
      wr_e   = q_wr && !s2_wr && q_cs;
      rd_e   = s2_rd && !q_rd && s2_cs;
      ifull  = inq.size() == DEPTH;
      iempty = inq.size() == 0;
      ofull  = outq.size() == DEPTH;
      oempty = outq.size() == 0;
      do_opop = 0; do_ipush = 0;
      if (rd_e) begin
        case (s2_a)
          2'd0: m_lat = DW'({m_unf, m_ovf, !oempty, !ifull});
          2'd1: m_lat = '0;
          2'd2: if (oempty) begin m_lat = '0; m_unf = 1; end
                else begin m_lat = outq[0]; do_opop = 1; end
          default: m_lat = DW'(m_en);
        endcase
      end
      if (wr_e) begin
        case (q_a)
          2'd0: begin if (q_d[2]) m_ovf = 0; if (q_d[3]) m_unf = 0; end
          2'd1: if (ifull) m_ovf = 1; else do_ipush = 1;
          2'd3: m_en = q_d[0];
          default: ;
        endcase
      end
      if (in_pop && !iempty) void'(inq.pop_front());
      if (do_ipush) inq.push_back(q_d);
      if (do_opop) void'(outq.pop_front());
      if (out_push && !ofull) outq.push_back(out_data);
      q_cs = s2_cs; q_rd = s2_rd; q_wr = s2_wr; q_a = s2_a; q_d = s2_d;
      s2_cs = s1_cs; s2_rd = s1_rd; s2_wr = s1_wr; s2_a = s1_a; s2_d = s1_d;
      s1_cs = !bus_cs_n; s1_rd = !bus_rd_n; s1_wr = !bus_wr_n; s1_a = bus_addr; s1_d = bus_din;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(in_valid == (inq.size() != 0), "R3 in_valid", in_valid, inq.size() != 0);
      if (inq.size() != 0) chk(in_data == inq[0], "R3 in_data order", in_data, inq[0]);
      chk(bus_ready == (inq.size() < DEPTH), "R4 bus_ready", bus_ready, inq.size() < DEPTH);
      chk(out_full == (outq.size() == DEPTH), "R10 out_full", out_full, outq.size() == DEPTH);
      chk(bus_req == (m_en && outq.size() != 0), "R8 bus_req", bus_req, m_en && outq.size() != 0);
      chk(bus_dout == m_lat, "R9 bus_dout latch", bus_dout, m_lat);
      chk(bus_doe == (!bus_cs_n && !bus_rd_n), "R9 bus_doe", bus_doe, !bus_cs_n && !bus_rd_n);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_cs_n = 0; bus_wr_n = 0;
    repeat (4) @(negedge clk);
    bus_wr_n = 1; bus_cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_cs_n = 0; bus_rd_n = 0;
    repeat (5) @(negedge clk);
    d = bus_dout;
    bus_rd_n = 1; bus_cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic logic_push(input logic [DW-1:0] d);
    @(negedge clk);
    out_data = d; out_push = 1;
    @(negedge clk);
    out_push = 0;
  endtask

  task automatic logic_pop();
    @(negedge clk);
    in_pop = 1;
    @(negedge clk);
    in_pop = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      finish_run();
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [DW-1:0] rv;
    rst_n = 0; bus_cs_n = 1; bus_rd_n = 1; bus_wr_n = 1; bus_addr = 0; bus_din = 0;
    in_pop = 0; out_push = 0; out_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(bus_req == 0, "R1 bus_req", bus_req, 0);
    chk(bus_ready == 1, "R1 bus_ready", bus_ready, 1);
    chk(in_valid == 0, "R1 in_valid", in_valid, 0);
    chk(out_full == 0, "R1 out_full", out_full, 0);
    chk(bus_dout == 0, "R1 bus_dout", bus_dout, 0);

    // R7 status after reset
    bus_read(2'd0, rv);
    chk(rv == 16'h0001, "R7 status idle", rv, 16'h0001);

    // R2 commit timing: visible on the third edge after release
    @(negedge clk);
    bus_addr = 2'd1; bus_din = 16'hA5A5; bus_cs_n = 0; bus_wr_n = 0;
    repeat (4) @(negedge clk);
    chk(in_valid == 0, "R2 no commit while strobe low", in_valid, 0);
    bus_wr_n = 1; bus_cs_n = 1;
    repeat (2) @(negedge clk);
    chk(in_valid == 0, "R2 not yet after two edges", in_valid, 0);
    @(negedge clk);
    chk(in_valid == 1 && in_data == 16'hA5A5, "R2 commit on third edge", in_data, 16'hA5A5);
    repeat (4) @(negedge clk);
    chk(in_valid == 1, "R2 single word only", in_valid, 1);

    // R3 order
    bus_write(2'd1, 16'h1111);
    bus_write(2'd1, 16'h2222);
    chk(in_data == 16'hA5A5, "R3 head first", in_data, 16'hA5A5);
    logic_pop();
    chk(in_data == 16'h1111, "R3 second", in_data, 16'h1111);
    logic_pop();
    chk(in_data == 16'h2222, "R3 third", in_data, 16'h2222);
    logic_pop();
    chk(in_valid == 0, "R3 drained", in_valid, 0);
    logic_pop();
    chk(in_valid == 0, "R10 pop on empty ignored", in_valid, 0);

    // R4 / R5 fill and overflow
    for (int i = 0; i < DEPTH; i++) bus_write(2'd1, DW'(16'h0100 + i));
    chk(bus_ready == 0, "R4 ready low when full", bus_ready, 0);
    bus_write(2'd1, 16'hDEAD);
    bus_read(2'd0, rv);
    chk(rv == 16'h0004, "R5 overflow flag set", rv, 16'h0004);
    bus_write(2'd0, 16'h0008);
    bus_read(2'd0, rv);
    chk(rv == 16'h0004, "R7 clear of other bit keeps overflow", rv, 16'h0004);
    bus_write(2'd0, 16'h0004);
    bus_read(2'd0, rv);
    chk(rv == 16'h0000, "R7 overflow cleared", rv, 16'h0000);
    for (int i = 0; i < DEPTH; i++) begin
      chk(in_data == DW'(16'h0100 + i), "R5 kept words intact", in_data, DW'(16'h0100 + i));
      logic_pop();
    end
    chk(bus_ready == 1, "R4 ready after drain", bus_ready, 1);

    // R8 / R6 outbox
    logic_push(16'hBEEF);
    logic_push(16'hCAFE);
    chk(bus_req == 0, "R8 req masked by enable", bus_req, 0);
    bus_write(2'd3, 16'h0001);
    chk(bus_req == 1, "R8 req raised", bus_req, 1);
    bus_read(2'd3, rv);
    chk(rv == 16'h0001, "R8 enable readback", rv, 16'h0001);
    bus_read(2'd2, rv);
    chk(rv == 16'hBEEF, "R6 first outbox word", rv, 16'hBEEF);
    bus_read(2'd2, rv);
    chk(rv == 16'hCAFE, "R6 second outbox word", rv, 16'hCAFE);
    chk(bus_req == 0, "R8 req low when empty", bus_req, 0);
    bus_read(2'd2, rv);
    chk(rv == 16'h0000, "R6 empty read returns zero", rv, 0);
    bus_read(2'd0, rv);
    chk(rv == 16'h0009, "R6 underflow in status", rv, 16'h0009);
    bus_write(2'd0, 16'h0008);
    bus_read(2'd0, rv);
    chk(rv == 16'h0001, "R7 underflow cleared", rv, 16'h0001);

    // R10 outbox overfill and ignored accesses
    for (int i = 0; i < DEPTH + 2; i++) logic_push(DW'(16'h0200 + i));
    chk(out_full == 1, "R10 out_full", out_full, 1);
    bus_read(2'd0, rv);
    chk(rv == 16'h0003, "R7 status with outbox data", rv, 16'h0003);
    bus_write(2'd2, 16'h7777);
    bus_read(2'd1, rv);
    chk(rv == 16'h0000, "R10 inbox offset reads zero", rv, 0);
    chk(in_valid == 0, "R10 outbox-offset write no inbox effect", in_valid, 0);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(2'd2, rv);
      chk(rv == DW'(16'h0200 + i), "R10 outbox content after drops", rv, DW'(16'h0200 + i));
    end
    bus_read(2'd0, rv);
    chk(rv == 16'h0001, "R10 extra pushes dropped", rv, 16'h0001);

    // R9 output enable
    @(negedge clk);
    bus_rd_n = 0;
    #1 chk(bus_doe == 0, "R9 doe needs chip select", bus_doe, 0);
    bus_rd_n = 1; bus_cs_n = 0; bus_wr_n = 0; bus_addr = 2'd0; bus_din = 0;
    #1 chk(bus_doe == 0, "R9 doe low on write", bus_doe, 0);
    bus_wr_n = 1; bus_cs_n = 1;
    repeat (6) @(negedge clk);

    finish_run();
  end
endmodule